// File: doc/BRIEF.md
# Card Ready/Busy Aggregator

This block combines the ready/busy lines of up to twelve flash devices on a card into one card-level ready/busy output. Any device can be left out of the combination through a per-device mask bit. Software reaches the block through a small 8-bit register port. The port holds the mask bits, a read-only image of each device's synchronised ready line, and a mode register.

There are two output modes. In level mode the card output is high only while every counted device is ready. In event mode the output stays low until a counted device moves from busy to ready. That event is captured in a pending bit, which drives the output high until the host clears it. Two summary outputs feed a card status register. One reports whether any device is masked. The other reports whether every device is ready, whatever the mask says.

Top module: `rdy_aggregator`

## Requirements
- R1: After `rst_ni` is asserted, all mask bits are 0, level mode is selected, the pending bit is 0, `card_rdy_o` is 0 and `any_masked_o` is 0.
- R2: In level mode (mode bit 0), `card_rdy_o` is 1 exactly when every synchronised device ready bit is 1 or masked.
- R3: In event mode (mode bit 1), a 0-to-1 transition of the synchronised ready bit of an unmasked device sets the pending bit on the next clock. `card_rdy_o` equals the pending bit, and the pending bit stays set when the device later goes busy.
- R4: A write to the mode register with bit 1 equal to 0 clears the pending bit. Writing bit 1 as 1 never sets it. A capture in the same cycle as a clear takes priority.
- R5: A masked device has no effect on `card_rdy_o`: neither its level in level mode nor its transitions in event mode.
- R6: Register map. Address 0 holds the mask for devices 7..0 (bit n = device n). Address 1 bits 3:0 hold the mask for devices 11..8. Addresses 2 and 3 hold the status bits in the same layout, 1 = ready. Address 4 holds the mode register: bit 0 is the mode (1 = event), bit 1 is the pending/acknowledge bit. Unused bits read 0.
- R7: `any_masked_o` is the OR of all mask bits. `all_ready_o` is 1 when every synchronised ready bit is 1, regardless of the mask.
- R8: Each device ready input passes through two flops. A change at the input affects `card_rdy_o` in level mode, and the status registers, after the second rising clock edge.
- R9: A high `card_rst_i` at a clock edge clears the mask bits, the mode bit and the pending bit.
- R10: Writes to the status addresses (2 and 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| card_rst_i | input | 1 | Synchronous card reset, active high |
| dev_rdy_i | input | 12 | Device ready lines, 1 = ready |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on addr_i) |
| card_rdy_o | output | 1 | Card ready/busy output |
| any_masked_o | output | 1 | Summary: some device is masked |
| all_ready_o | output | 1 | Summary: every device is ready |

## Verification
The first patterns are directed ones:
- All devices ready, then one device busy, then that device masked. This separates the AND-with-mask combination from a plain AND.
- In event mode, a single device rising, then falling. This shows the event is held, not followed as a level.
- Rising edges on masked devices, and acknowledges written as 1 rather than 0. These separate the conditions that must capture or clear an event from those that must not.

A long phase of random ready lines, mask writes and mode writes then compares the outputs against a behavioural model on every clock. This phase reaches clears that coincide with captures, and mode switches with an event already pending.

// File: rtl/rdy_agg_pkg.sv
package rdy_agg_pkg;
  typedef struct packed {
    logic pend;
    logic evt_mode;
  } mode_t;

  function automatic int unsigned n_bytes(int unsigned n_dev, int unsigned dw);
    return (n_dev + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] d_prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign s_o      = s2_q;
  assign d_prev_o = s3_q;
endmodule

// File: rtl/rdy_regs.sv
module rdy_regs
  import rdy_agg_pkg::*;
#(
  parameter int unsigned N_DEV  = 12,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             card_rst_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_DEV-1:0] rdy_s_i,
  input  logic             rise_any_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_DEV-1:0] mask_o,
  output mode_t            mode_o
);
  localparam int unsigned NB   = n_bytes(N_DEV, DW);
  localparam int unsigned PADW = NB * DW;
  localparam int unsigned MODE_ADDR = 2 * NB;

  logic [N_DEV-1:0] mask_q, mask_d;
  mode_t            mode_q, mode_d;
  logic [PADW-1:0]  mask_pad, stat_pad, mask_wr;
  logic             mode_wr;

  always_comb begin
    mask_pad = '0;
    mask_pad[N_DEV-1:0] = mask_q;
    stat_pad = '0;
    stat_pad[N_DEV-1:0] = rdy_s_i;
  end

  always_comb begin
    mask_wr = mask_pad;
    for (int i = 0; i < NB; i++) begin
      if (wr_en_i && addr_i == AW'(i)) mask_wr[i*DW +: DW] = wdata_i;
    end
    mask_d = mask_wr[N_DEV-1:0];
  end

  assign mode_wr = wr_en_i && (addr_i == AW'(MODE_ADDR));

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) begin
      mode_d.evt_mode = wdata_i[0];
      if (!wdata_i[1]) mode_d.pend = 1'b0;
    end
    // capture wins over a simultaneous clear
    if (mode_q.evt_mode && rise_any_i) mode_d.pend = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= '0;
    end else if (card_rst_i) begin
      mask_q <= '0;
      mode_q <= '0;
    end else begin
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == AW'(i))      rdata_o = mask_pad[i*DW +: DW];
      if (addr_i == AW'(NB + i)) rdata_o = stat_pad[i*DW +: DW];
    end
    if (addr_i == AW'(MODE_ADDR)) rdata_o = DW'(mode_q);
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/rdy_combine.sv
module rdy_combine
  import rdy_agg_pkg::*;
#(
  parameter int unsigned N_DEV = 12
) (
  input  logic [N_DEV-1:0] rdy_s_i,
  input  logic [N_DEV-1:0] rdy_d_i,
  input  logic [N_DEV-1:0] mask_i,
  input  mode_t            mode_i,
  output logic             rise_any_o,
  output logic             card_rdy_o,
  output logic             any_masked_o,
  output logic             all_ready_o
);
  logic [N_DEV-1:0] counted_rdy;
  logic [N_DEV-1:0] rise_vec;

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign counted_rdy[g] = rdy_s_i[g] | mask_i[g];
    assign rise_vec[g]    = rdy_s_i[g] & ~rdy_d_i[g] & ~mask_i[g];
  end

  assign rise_any_o   = |rise_vec;
  assign card_rdy_o   = mode_i.evt_mode ? mode_i.pend : &counted_rdy;
  assign any_masked_o = |mask_i;
  assign all_ready_o  = &rdy_s_i;
endmodule

// File: rtl/rdy_aggregator.sv
module rdy_aggregator
  import rdy_agg_pkg::*;
#(
  parameter int unsigned N_DEV = 12,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             card_rst_i,
  input  logic [N_DEV-1:0] dev_rdy_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             card_rdy_o,
  output logic             any_masked_o,
  output logic             all_ready_o
);
  logic [N_DEV-1:0] rdy_s, rdy_d, mask_q;
  mode_t            mode_q;
  logic             rise_any;

  rdy_sync #(.W(N_DEV)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (dev_rdy_i),
    .s_o      (rdy_s),
    .d_prev_o (rdy_d)
  );

  rdy_regs #(.N_DEV(N_DEV), .DW(DW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .card_rst_i (card_rst_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdy_s_i    (rdy_s),
    .rise_any_i (rise_any),
    .rdata_o    (rdata_o),
    .mask_o     (mask_q),
    .mode_o     (mode_q)
  );

  rdy_combine #(.N_DEV(N_DEV)) u_comb (
    .rdy_s_i      (rdy_s),
    .rdy_d_i      (rdy_d),
    .mask_i       (mask_q),
    .mode_i       (mode_q),
    .rise_any_o   (rise_any),
    .card_rdy_o   (card_rdy_o),
    .any_masked_o (any_masked_o),
    .all_ready_o  (all_ready_o)
  );
endmodule

// File: rtl/rdy_aggregator_chk.sv
module rdy_aggregator_chk
  import rdy_agg_pkg::*;
#(
  parameter int unsigned N_DEV = 12,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             card_rst_i,
  input logic [N_DEV-1:0] dev_rdy_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             card_rdy_o,
  input logic             any_masked_o,
  input logic [N_DEV-1:0] rdy_s,
  input logic [N_DEV-1:0] rdy_d,
  input logic [N_DEV-1:0] mask_q,
  input mode_t            mode_q
);
  localparam int unsigned MODE_ADDR = 2 * n_bytes(N_DEV, DW);
  logic [1:0] cyc_q;
  logic       clr_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (cyc_q != 3) cyc_q <= cyc_q + 2'd1;
  end

  assign clr_wr = wr_en_i && addr_i == AW'(MODE_ADDR) && !wdata_i[1];

  // R2
  a_r2_level_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.evt_mode |-> card_rdy_o == &(rdy_s | mask_q));
  // R3
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.evt_mode && !card_rst_i && |(rdy_s & ~rdy_d & ~mask_q)) |=> mode_q.pend);
  // R4
  a_r4_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.pend && !clr_wr && !card_rst_i) |=> mode_q.pend);
  // R4
  a_r4_no_set_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.pend && !mode_q.evt_mode) |=> !mode_q.pend);
  // R7
  a_r7_any_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_masked_o == (mask_q != '0));
  // R8
  a_r8_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> rdy_s == $past(dev_rdy_i, 2));
  // R9
  a_r9_card_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_i |=> (mask_q == '0 && mode_q == '0));
endmodule

bind rdy_aggregator rdy_aggregator_chk #(.N_DEV(N_DEV), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/rdy_aggregator_test.sv
module rdy_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_rst = 1'b0;
  logic [11:0] dev = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata;
  logic        card_rdy, any_masked, all_ready;

  int total = 0, bad = 0;
  bit live_cmp = 1'b0;

  always #2 clk = ~clk;

  rdy_aggregator uut (
    .clk_i(clk), .rst_ni(rst_n), .card_rst_i(card_rst), .dev_rdy_i(dev),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wd), .rdata_o(rdata),
    .card_rdy_o(card_rdy), .any_masked_o(any_masked), .all_ready_o(all_ready)
  );

  // behavioural reference
  logic [11:0] m_s1, m_s2, m_d, m_mask;
  bit m_evt, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_d <= '0; m_mask <= '0; m_evt <= 0; m_pend <= 0;
    end else begin
      m_s1 <= dev; m_s2 <= m_s1; m_d <= m_s2;
      if (card_rst) begin
        m_mask <= '0; m_evt <= 0; m_pend <= 0;
      end else begin
        if (we && addr == 3'd0) m_mask[7:0] <= wd;
        if (we && addr == 3'd1) m_mask[11:8] <= wd[3:0];
        if (we && addr == 3'd4) m_evt <= wd[0];
        if (m_evt && ((m_s2 & ~m_d & ~m_mask) != 0)) m_pend <= 1;
        else if (we && addr == 3'd4 && !wd[1]) m_pend <= 0;
      end
    end
  end

  function automatic bit exp_card();
    if (m_evt) return m_pend;
    return &(m_s2 | m_mask);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live_cmp && rst_n) begin
      chk(m_evt ? "R3 event out" : "R2 level out", card_rdy, exp_card());
      chk("R7 any_masked", any_masked, (m_mask != 0));
      chk("R7 all_ready", all_ready, (&m_s2));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 card_rdy reset", card_rdy, 0);
    chk("R1 any_masked reset", any_masked, 0);
    rst_n = 1'b1;
    rd(3'd0, 8'h00, "R1 mask lo reset");
    rd(3'd4, 8'h00, "R1 mode reset");
    live_cmp = 1'b1;

    // R8: two-edge latency
    @(negedge clk); dev = 12'hFFF;
    @(negedge clk); #1 chk("R8 one edge still low", card_rdy, 0);
    @(negedge clk); #1 chk("R8 two edges high", card_rdy, 1);
    rd(3'd2, 8'hFF, "R6 status lo");
    rd(3'd3, 8'h0F, "R6 status hi");

    // R2 / R5 level mode with mask
    dev[5] = 0; cyc(3);
    chk("R2 busy device lowers", card_rdy, 0);
    wr(3'd0, 8'h20); cyc(1);
    chk("R5 masked busy ignored", card_rdy, 1);
    chk("R7 all_ready ignores mask", all_ready, 0);
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R6 mask hi reserved zero");
    wr(3'd1, 8'h04);
    rd(3'd1, 8'h04, "R6 mask hi dev10");

    // R10 status read-only
    wr(3'd2, 8'h00);
    rd(3'd2, 8'hDF, "R10 status write ignored");

    // event mode
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    dev = '0; cyc(3);
    wr(3'd4, 8'h01); cyc(2);
    chk("R3 event idle low", card_rdy, 0);
    @(negedge clk); dev[3] = 1;
    cyc(2); #1 chk("R3 not yet captured", card_rdy, 0);
    cyc(1); #1 chk("R3 captured", card_rdy, 1);
    dev[3] = 0; cyc(4);
    chk("R3 held after busy", card_rdy, 1);
    rd(3'd4, 8'h03, "R6 mode reads pend");
    wr(3'd4, 8'h03); cyc(1);
    chk("R4 write 1 keeps pend", card_rdy, 1);
    wr(3'd4, 8'h01); cyc(1);
    chk("R4 clear drops output", card_rdy, 0);
    wr(3'd4, 8'h03); cyc(1);
    chk("R4 write 1 does not set", card_rdy, 0);
    wr(3'd0, 8'h01);
    @(negedge clk); dev[0] = 1; cyc(4);
    chk("R5 masked rise ignored", card_rdy, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      dev = 12'($urandom);
      we = ($urandom % 4) == 0;
      addr = 3'($urandom % 5);
      wd = 8'($urandom);
      if (($urandom % 2) == 0) wd[1] = 0;
    end
    we = 0;

    // R9 card reset
    wr(3'd0, 8'hAA); wr(3'd4, 8'h01);
    @(negedge clk); card_rst = 1;
    @(negedge clk); card_rst = 0;
    rd(3'd0, 8'h00, "R9 mask cleared");
    rd(3'd4, 8'h00, "R9 mode cleared");
    chk("R9 any_masked cleared", any_masked, 0);

    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule